// File: doc/BRIEF.md
# Arbitrated Dual-Port RAM with Semaphores and Mailbox Interrupts

This block is a synchronous model of a word-addressed memory shared by two independent processor ports, called left and right. Each port has its own active-low chip select, write line, output enable, upper and lower byte selects and semaphore select, plus an address, write data and read data. Both ports may read or write any word in the same clock cycle. When both ports reach the same word and at least one of them writes, an arbiter picks a winner. The losing port sees its busy flag and its write is dropped.

Beside the array sit eight hardware semaphore flags, reached through the semaphore select. Two processors use them to claim shared regions. The two words at the top of the address space work as mailboxes. Writing one of them raises an interrupt flag on the other port, and that port clears the flag by reading the same word. A mode input picks master operation, where the busy flags come from the internal arbiter, or slave operation, where busy comes in from outside. Slave mode lets several devices side by side share one arbiter when a wider word is built.

The array depth is set by `ADDR_W`. The default is 10, which gives 1024 words for elaboration. Setting it to 13 gives the full 8192 x 16 organisation. Index 0 of every internal two-entry vector is the left port and index 1 is the right port.

Top module: `twin_port_mem`

## Requirements
- R1: A port makes a RAM access in a cycle only when its `cs_n` is 0, its `sem_n` is 1 and at least one of `ub_n`/`lb_n` is 0. `we_n`=0 makes the access a write and `we_n`=1 makes it a read. Any other combination, including `cs_n`=1 with `sem_n`=1 or `cs_n`=0 with `sem_n`=0, performs no access: nothing is written and the read result for that cycle is zero.
- R2: `ub_n`=0 enables bits 15:8 and `lb_n`=0 enables bits 7:0. A write changes only the enabled bytes. A read returns zero in every byte that is not enabled.
- R3: A RAM read returns the word as it stood before any write at the same clock edge. The value appears on `rdata` just after that edge and stays for exactly one cycle. After a cycle with no read, `rdata` is zero.
- R4: While a port's `oe_n` is 1, its `rdata` is zero in the same cycle. The registered read result is only masked, not lost.
- R5: In master mode, a conflict is a cycle in which both ports make RAM accesses to the same address and at least one of them writes. In a conflict exactly one port is busy, in that same cycle. The busy port's write is dropped, but its read still happens. Outside a conflict neither busy flag is set.
- R6: The winner of a conflict is the port whose access to that address was already present in the previous cycle while the other port's was not. When both are new, the left port wins. When both were already present, the previous cycle's winner keeps winning, and the left port wins if the previous cycle had no conflict.
- R7: With `master_mode`=0, each busy output equals that port's `busy_in`, no internal arbitration takes place, and a port's write is dropped while its `busy_in` is 1. With `master_mode`=1, the `busy_in` inputs have no effect.
- R8: A port makes a semaphore access when `cs_n`=1 and `sem_n`=0. Address bits 2:0 select one of eight flags. A semaphore access never changes the RAM.
- R9: A semaphore write with data bit 0 = 0 claims the flag if it is free. A write with bit 0 = 1 frees the flag only when the writing port owns it. Any other write is ignored. A semaphore read returns 16'h0000 to the owner and 16'h0001 to anyone else. The value appears one cycle later and reflects the state before that edge.
- R10: When both ports claim the same free flag in the same cycle, the left port gets it.
- R11: A RAM write by the left port to the top address (all ones) that is not dropped sets `r_irq`. A right-port RAM read of that address clears it. A right-port write to the top address minus one sets `l_irq`, and a left-port read of that address clears it. A set wins over a clear in the same cycle. Both flags change at the clock edge.
- R12: Synchronous reset clears both interrupt flags, frees all semaphores, zeroes the read registers and forgets the arbitration history. RAM contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1: internal arbitration, 0: busy taken from the inputs |
| l_busy_in | input | 1 | Left busy input used in slave mode |
| r_busy_in | input | 1 | Right busy input used in slave mode |
| l_cs_n | input | 1 | Left chip select, active low |
| l_we_n | input | 1 | Left write (0) or read (1) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper byte select, active low |
| l_lb_n | input | 1 | Left lower byte select, active low |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data |
| l_busy | output | 1 | Left port lost arbitration this cycle |
| l_irq | output | 1 | Left mailbox interrupt flag |
| r_cs_n | input | 1 | Right chip select, active low |
| r_we_n | input | 1 | Right write (0) or read (1) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper byte select, active low |
| r_lb_n | input | 1 | Right lower byte select, active low |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data |
| r_busy | output | 1 | Right port lost arbitration this cycle |
| r_irq | output | 1 | Right mailbox interrupt flag |

## Verification
The busy flags and the output-enable masking depend on the inputs of the current cycle, so they are due in the same cycle as the stimulus. Read data, semaphore status and the interrupt flags each pass through one register and are due just after the clock edge that samples the access. The bench drives new inputs on the falling edge and compares every output shortly after it. At that point the busy flags reflect the fresh inputs, while the registered outputs reflect the previous rising edge. The reference model advances on each rising edge from the same inputs, so each result is compared in exactly the cycle it is due.

// File: rtl/twin_port_pkg.sv
package twin_port_pkg;

    localparam int WORD_W     = 16;
    localparam int LANE_W     = 8;
    localparam int SEM_COUNT  = 8;
    localparam int SEM_SEL_W  = $clog2(SEM_COUNT);

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_RAM  = 2'd1,
        ACC_SEM  = 2'd2
    } acc_kind_t;

    typedef struct packed {
        acc_kind_t  kind;
        logic       write;
        logic [1:0] lanes;   // [1] upper byte, [0] lower byte
    } access_t;

    typedef enum logic [1:0] {
        OWN_FREE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } sem_owner_t;

    function automatic access_t decode_access(input logic cs_n, input logic sem_n,
                                              input logic ub_n, input logic lb_n,
                                              input logic we_n);
        access_t a;
        a.lanes = {~ub_n, ~lb_n};
        a.write = ~we_n;
        if (!cs_n && sem_n && (a.lanes != 2'b00))
            a.kind = ACC_RAM;
        else if (cs_n && !sem_n)
            a.kind = ACC_SEM;
        else
            a.kind = ACC_IDLE;
        return a;
    endfunction

    function automatic logic [WORD_W-1:0] lane_mask(input logic [1:0] lanes);
        return {{LANE_W{lanes[1]}}, {LANE_W{lanes[0]}}};
    endfunction

endpackage

// File: rtl/tpm_arbiter.sv
module tpm_arbiter
    import twin_port_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   master_mode,
    input  logic [1:0]             busy_in,
    input  logic [1:0]             ram_act,
    input  logic [1:0]             wr_req,
    input  logic [1:0][ADDR_W-1:0] port_addr,
    output logic [1:0]             busy,
    output logic [1:0]             wr_ok
);

    logic [1:0]             prev_act;
    logic [1:0][ADDR_W-1:0] prev_addr;
    logic                   right_won;
    logic [1:0]             held;
    logic                   conflict;
    logic                   left_wins;
    logic [1:0]             busy_int;

    always_comb begin
        for (int p = 0; p < 2; p++)
            held[p] = ram_act[p] && prev_act[p] && (prev_addr[p] == port_addr[p]);
        conflict = (ram_act == 2'b11) && (port_addr[0] == port_addr[1]) && (wr_req != 2'b00);
        case (held)
            2'b01:   left_wins = 1'b1;
            2'b10:   left_wins = 1'b0;
            2'b11:   left_wins = ~right_won;
            default: left_wins = 1'b1;
        endcase
        busy_int = conflict ? (left_wins ? 2'b10 : 2'b01) : 2'b00;
        busy     = master_mode ? busy_int : busy_in;
        wr_ok    = ram_act & wr_req & ~busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_act  <= '0;
            prev_addr <= '0;
            right_won <= 1'b0;
        end else begin
            prev_act  <= ram_act;
            prev_addr <= port_addr;
            right_won <= master_mode && conflict && !left_wins;
        end
    end

    // R5
    one_loser_chk: assert property (@(posedge clk) disable iff (rst)
        master_mode |-> (busy != 2'b11));

    // R6
    winner_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (master_mode && $past(master_mode) && conflict && $past(conflict) && held == 2'b11)
        |-> (busy == $past(busy)));

endmodule

// File: rtl/tpm_store.sv
module tpm_store
    import twin_port_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             rd_en,
    input  logic [1:0]             wr_en,
    input  logic [1:0][1:0]        lanes,
    input  logic [1:0][ADDR_W-1:0] addr,
    input  logic [1:0][WORD_W-1:0] wdata,
    output logic [1:0][WORD_W-1:0] q
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int p = 0; p < 2; p++) begin
            if (wr_en[p]) begin
                if (lanes[p][1]) mem[addr[p]][WORD_W-1:LANE_W] <= wdata[p][WORD_W-1:LANE_W];
                if (lanes[p][0]) mem[addr[p]][LANE_W-1:0]      <= wdata[p][LANE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            for (int p = 0; p < 2; p++)
                q[p] <= rd_en[p] ? (mem[addr[p]] & lane_mask(lanes[p])) : '0;
        end
    end

    generate
        for (genvar p = 0; p < 2; p++) begin : g_rd_chk
            // R3
            idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
                !rd_en[p] |=> (q[p] == '0));
        end
    endgenerate

endmodule

// File: rtl/tpm_semaphores.sv
module tpm_semaphores
    import twin_port_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                sem_wr,
    input  logic [1:0]                sem_rd,
    input  logic [1:0][SEM_SEL_W-1:0] sel,
    input  logic [1:0]                wbit,
    output logic [1:0][WORD_W-1:0]    q
);

    sem_owner_t owner [SEM_COUNT];

    generate
        for (genvar f = 0; f < SEM_COUNT; f++) begin : g_flag
            logic l_claim, r_claim, l_free, r_free;
            always_comb begin
                l_claim = sem_wr[0] && (sel[0] == SEM_SEL_W'(f)) && !wbit[0];
                r_claim = sem_wr[1] && (sel[1] == SEM_SEL_W'(f)) && !wbit[1];
                l_free  = sem_wr[0] && (sel[0] == SEM_SEL_W'(f)) &&  wbit[0];
                r_free  = sem_wr[1] && (sel[1] == SEM_SEL_W'(f)) &&  wbit[1];
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    owner[f] <= OWN_FREE;
                end else begin
                    case (owner[f])
                        OWN_FREE: begin
                            if (l_claim)      owner[f] <= OWN_LEFT;
                            else if (r_claim) owner[f] <= OWN_RIGHT;
                        end
                        OWN_LEFT:  if (l_free) owner[f] <= OWN_FREE;
                        OWN_RIGHT: if (r_free) owner[f] <= OWN_FREE;
                        default:   owner[f] <= OWN_FREE;
                    endcase
                end
            end

            // R9
            no_steal_l_chk: assert property (@(posedge clk) disable iff (rst)
                (owner[f] == OWN_LEFT) |=> (owner[f] != OWN_RIGHT));
            // R9
            no_steal_r_chk: assert property (@(posedge clk) disable iff (rst)
                (owner[f] == OWN_RIGHT) |=> (owner[f] != OWN_LEFT));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            for (int p = 0; p < 2; p++) begin
                if (sem_rd[p])
                    q[p] <= (owner[sel[p]] == ((p == 0) ? OWN_LEFT : OWN_RIGHT))
                            ? WORD_W'(0) : WORD_W'(1);
                else
                    q[p] <= '0;
            end
        end
    end

endmodule

// File: rtl/tpm_mailbox.sv
module tpm_mailbox #(
    parameter int ADDR_W = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             wr_ok,
    input  logic [1:0]             rd_en,
    input  logic [1:0][ADDR_W-1:0] addr,
    output logic [1:0]             irq
);

    localparam logic [ADDR_W-1:0] BOX_TO_R = '1;
    localparam logic [ADDR_W-1:0] BOX_TO_L = BOX_TO_R - 1'b1;

    logic [1:0] set_v, clr_v;

    generate
        for (genvar p = 0; p < 2; p++) begin : g_box
            localparam int SRC = 1 - p;
            localparam logic [ADDR_W-1:0] BOX = (p == 0) ? BOX_TO_L : BOX_TO_R;
            assign set_v[p] = wr_ok[SRC] && (addr[SRC] == BOX);
            assign clr_v[p] = rd_en[p]   && (addr[p]   == BOX);

            // R11
            irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(irq[p]) |-> $past(set_v[p]));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= '0;
        end else begin
            for (int p = 0; p < 2; p++) begin
                if (set_v[p])      irq[p] <= 1'b1;
                else if (clr_v[p]) irq[p] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/twin_port_mem.sv
module twin_port_mem
    import twin_port_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_mode,
    input  logic              l_busy_in,
    input  logic              r_busy_in,
    input  logic              l_cs_n,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic              l_ub_n,
    input  logic              l_lb_n,
    input  logic              l_sem_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [WORD_W-1:0] l_wdata,
    output logic [WORD_W-1:0] l_rdata,
    output logic              l_busy,
    output logic              l_irq,
    input  logic              r_cs_n,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic              r_ub_n,
    input  logic              r_lb_n,
    input  logic              r_sem_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [WORD_W-1:0] r_wdata,
    output logic [WORD_W-1:0] r_rdata,
    output logic              r_busy,
    output logic              r_irq
);

    access_t                  acc [2];
    logic [1:0][ADDR_W-1:0]   addr_v;
    logic [1:0][WORD_W-1:0]   wdata_v;
    logic [1:0][1:0]          lanes_v;
    logic [1:0]               ram_act, ram_rd, wr_req, sem_wr, sem_rd;
    logic [1:0][SEM_SEL_W-1:0] sem_sel;
    logic [1:0]               sem_bit;
    logic [1:0]               busy_v, wr_ok, irq_v;
    logic [1:0][WORD_W-1:0]   ram_q, sem_q;

    assign acc[0]     = decode_access(l_cs_n, l_sem_n, l_ub_n, l_lb_n, l_we_n);
    assign acc[1]     = decode_access(r_cs_n, r_sem_n, r_ub_n, r_lb_n, r_we_n);
    assign addr_v[0]  = l_addr;
    assign addr_v[1]  = r_addr;
    assign wdata_v[0] = l_wdata;
    assign wdata_v[1] = r_wdata;

    generate
        for (genvar p = 0; p < 2; p++) begin : g_port
            assign ram_act[p] = (acc[p].kind == ACC_RAM);
            assign wr_req[p]  = ram_act[p] &&  acc[p].write;
            assign ram_rd[p]  = ram_act[p] && !acc[p].write;
            assign sem_wr[p]  = (acc[p].kind == ACC_SEM) &&  acc[p].write;
            assign sem_rd[p]  = (acc[p].kind == ACC_SEM) && !acc[p].write;
            assign lanes_v[p] = acc[p].lanes;
            assign sem_sel[p] = addr_v[p][SEM_SEL_W-1:0];
            assign sem_bit[p] = wdata_v[p][0];
        end
    endgenerate

    tpm_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk(clk), .rst(rst), .master_mode(master_mode),
        .busy_in({r_busy_in, l_busy_in}), .ram_act(ram_act), .wr_req(wr_req),
        .port_addr(addr_v), .busy(busy_v), .wr_ok(wr_ok)
    );

    tpm_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst(rst), .rd_en(ram_rd), .wr_en(wr_ok), .lanes(lanes_v),
        .addr(addr_v), .wdata(wdata_v), .q(ram_q)
    );

    tpm_semaphores u_sem (
        .clk(clk), .rst(rst), .sem_wr(sem_wr), .sem_rd(sem_rd),
        .sel(sem_sel), .wbit(sem_bit), .q(sem_q)
    );

    tpm_mailbox #(.ADDR_W(ADDR_W)) u_box (
        .clk(clk), .rst(rst), .wr_ok(wr_ok), .rd_en(ram_rd),
        .addr(addr_v), .irq(irq_v)
    );

    assign l_rdata = l_oe_n ? '0 : (ram_q[0] | sem_q[0]);
    assign r_rdata = r_oe_n ? '0 : (ram_q[1] | sem_q[1]);
    assign l_busy  = busy_v[0];
    assign r_busy  = busy_v[1];
    assign l_irq   = irq_v[0];
    assign r_irq   = irq_v[1];

    // R7
    slave_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !master_mode |-> ((wr_ok & {r_busy_in, l_busy_in}) == 2'b00));

    // R8
    sem_no_ram_chk: assert property (@(posedge clk) disable iff (rst)
        ((acc[0].kind == ACC_SEM) |-> !wr_ok[0]) and ((acc[1].kind == ACC_SEM) |-> !wr_ok[1]));

endmodule

// File: tb/twin_port_mem_bench.sv
module twin_port_mem_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 10;
    localparam int DEPTH      = 1 << AW;
    localparam logic [AW-1:0] TOP = '1;

    typedef struct packed {
        logic          cs_n;
        logic          we_n;
        logic          oe_n;
        logic          ub_n;
        logic          lb_n;
        logic          sem_n;
        logic [AW-1:0] addr;
        logic [15:0]   wdata;
    } pin_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic master = 1'b1;
    logic lbi = 1'b0, rbi = 1'b0;
    pin_t pl, pr;

    logic [15:0] l_rdata, r_rdata;
    logic        l_busy, r_busy, l_irq, r_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string cur_req = "R12";

    // reference model state
    logic [15:0]   mem_m [DEPTH];
    int            sem_m [8];
    logic          irq_l_m = 1'b0, irq_r_m = 1'b0;
    logic [15:0]   rq_l = '0, rq_r = '0;
    logic [1:0]    pv_act = '0;
    logic [AW-1:0] pv_addr [2];
    logic          last_r = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twin_port_mem #(.ADDR_W(AW)) u_twin_port_mem (
        .clk(clk), .rst(rst), .master_mode(master),
        .l_busy_in(lbi), .r_busy_in(rbi),
        .l_cs_n(pl.cs_n), .l_we_n(pl.we_n), .l_oe_n(pl.oe_n), .l_ub_n(pl.ub_n),
        .l_lb_n(pl.lb_n), .l_sem_n(pl.sem_n), .l_addr(pl.addr), .l_wdata(pl.wdata),
        .l_rdata(l_rdata), .l_busy(l_busy), .l_irq(l_irq),
        .r_cs_n(pr.cs_n), .r_we_n(pr.we_n), .r_oe_n(pr.oe_n), .r_ub_n(pr.ub_n),
        .r_lb_n(pr.lb_n), .r_sem_n(pr.sem_n), .r_addr(pr.addr), .r_wdata(pr.wdata),
        .r_rdata(r_rdata), .r_busy(r_busy), .r_irq(r_irq)
    );

    // stimulus helpers
    function automatic pin_t p_idle();
        pin_t x = '0;
        x.cs_n = 1'b1; x.we_n = 1'b1; x.ub_n = 1'b1; x.lb_n = 1'b1; x.sem_n = 1'b1;
        return x;
    endfunction

    function automatic pin_t p_wr(logic [AW-1:0] a, logic [15:0] d, bit ub = 1, bit lb = 1);
        pin_t x = p_idle();
        x.cs_n = 1'b0; x.we_n = 1'b0; x.ub_n = !ub; x.lb_n = !lb; x.addr = a; x.wdata = d;
        return x;
    endfunction

    function automatic pin_t p_rd(logic [AW-1:0] a, bit ub = 1, bit lb = 1);
        pin_t x = p_idle();
        x.cs_n = 1'b0; x.ub_n = !ub; x.lb_n = !lb; x.addr = a;
        return x;
    endfunction

    function automatic pin_t p_sw(logic [AW-1:0] a, bit b0);
        pin_t x = p_idle();
        x.sem_n = 1'b0; x.we_n = 1'b0; x.addr = a; x.wdata = {15'h5A5A, b0};
        return x;
    endfunction

    function automatic pin_t p_sr(logic [AW-1:0] a);
        pin_t x = p_idle();
        x.sem_n = 1'b0; x.addr = a;
        return x;
    endfunction

    function automatic bit is_ram(pin_t x);
        return !x.cs_n && x.sem_n && (!x.ub_n || !x.lb_n);
    endfunction

    function automatic bit is_sem(pin_t x);
        return x.cs_n && !x.sem_n;
    endfunction

    function automatic logic [15:0] lanes_of(pin_t x);
        return {{8{!x.ub_n}}, {8{!x.lb_n}}};
    endfunction

    // expected busy from the current inputs and model history
    task automatic eval_busy(output bit bl, output bit br, output bit confl, output bit winl);
        bit al, ar, hl, hr;
        al = is_ram(pl);
        ar = is_ram(pr);
        hl = al && pv_act[0] && (pv_addr[0] == pl.addr);
        hr = ar && pv_act[1] && (pv_addr[1] == pr.addr);
        confl = al && ar && (pl.addr == pr.addr) && (!pl.we_n || !pr.we_n);
        if (hl && !hr)      winl = 1;
        else if (hr && !hl) winl = 0;
        else if (hl && hr)  winl = !last_r;
        else                winl = 1;
        if (master) begin
            bl = confl && !winl;
            br = confl && winl;
        end else begin
            bl = lbi;
            br = rbi;
        end
    endtask

    task automatic model_step();
        bit bl, br, confl, winl, al, ar, wl, wr, sl, sr;
        logic [15:0] nl, nr;
        int nsem [8];
        if (rst) begin
            irq_l_m = 0; irq_r_m = 0; rq_l = '0; rq_r = '0;
            pv_act = '0; pv_addr[0] = '0; pv_addr[1] = '0; last_r = 0;
            for (int f = 0; f < 8; f++) sem_m[f] = 0;
            return;
        end
        eval_busy(bl, br, confl, winl);
        al = is_ram(pl); ar = is_ram(pr);
        sl = is_sem(pl); sr = is_sem(pr);
        wl = al && !pl.we_n && !bl;
        wr = ar && !pr.we_n && !br;
        if (al && pl.we_n)      nl = mem_m[pl.addr] & lanes_of(pl);
        else if (sl && pl.we_n) nl = (sem_m[pl.addr[2:0]] == 1) ? 16'h0000 : 16'h0001;
        else                    nl = '0;
        if (ar && pr.we_n)      nr = mem_m[pr.addr] & lanes_of(pr);
        else if (sr && pr.we_n) nr = (sem_m[pr.addr[2:0]] == 2) ? 16'h0000 : 16'h0001;
        else                    nr = '0;
        rq_l = nl; rq_r = nr;
        if (wl && pl.addr == TOP) irq_r_m = 1;
        else if (ar && pr.we_n && pr.addr == TOP) irq_r_m = 0;
        if (wr && pr.addr == TOP - 1) irq_l_m = 1;
        else if (al && pl.we_n && pl.addr == TOP - 1) irq_l_m = 0;
        if (wl) mem_m[pl.addr] = (mem_m[pl.addr] & ~lanes_of(pl)) | (pl.wdata & lanes_of(pl));
        if (wr) mem_m[pr.addr] = (mem_m[pr.addr] & ~lanes_of(pr)) | (pr.wdata & lanes_of(pr));
        for (int f = 0; f < 8; f++) begin
            bit lc, rc, lf, rf;
            lc = sl && !pl.we_n && pl.addr[2:0] == f && !pl.wdata[0];
            rc = sr && !pr.we_n && pr.addr[2:0] == f && !pr.wdata[0];
            lf = sl && !pl.we_n && pl.addr[2:0] == f &&  pl.wdata[0];
            rf = sr && !pr.we_n && pr.addr[2:0] == f &&  pr.wdata[0];
            nsem[f] = sem_m[f];
            if (sem_m[f] == 0)      nsem[f] = lc ? 1 : (rc ? 2 : 0);
            else if (sem_m[f] == 1) nsem[f] = lf ? 0 : 1;
            else                    nsem[f] = rf ? 0 : 2;
        end
        for (int f = 0; f < 8; f++) sem_m[f] = nsem[f];
        pv_act = {ar, al};
        pv_addr[0] = pl.addr; pv_addr[1] = pr.addr;
        last_r = master && confl && !winl;
    endtask

    task automatic check(string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // compare all outputs shortly after the falling edge, then advance one cycle
    task automatic tick();
        bit bl, br, confl, winl;
        #1;
        eval_busy(bl, br, confl, winl);
        check("l_rdata", l_rdata, pl.oe_n ? 16'h0 : rq_l);
        check("r_rdata", r_rdata, pr.oe_n ? 16'h0 : rq_r);
        check("l_busy", {15'h0, l_busy}, {15'h0, bl});
        check("r_busy", {15'h0, r_busy}, {15'h0, br});
        check("l_irq", {15'h0, l_irq}, {15'h0, irq_l_m});
        check("r_irq", {15'h0, r_irq}, {15'h0, irq_r_m});
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic cyc(pin_t a, pin_t b);
        pl = a; pr = b;
        tick();
    endtask

    initial begin
        pl = p_idle(); pr = p_idle();
        for (int i = 0; i < 2; i++) pv_addr[i] = '0;
        for (int f = 0; f < 8; f++) sem_m[f] = 0;
        @(posedge clk); model_step();
        @(negedge clk);
        cur_req = "R12";
        tick(); tick();
        rst = 1'b0;
        cyc(p_idle(), p_idle());

        cur_req = "R1";
        cyc(p_wr(5, 16'hA5A5), p_idle());
        cyc(p_rd(5), p_rd(5));
        cyc(p_idle(), p_idle());

        cur_req = "R2";
        cyc(p_wr(5, 16'h1234, 1, 0), p_idle());
        cyc(p_idle(), p_rd(5, 0, 1));
        cyc(p_idle(), p_rd(5));
        cyc(p_wr(6, 16'hBEEF, 0, 1), p_wr(7, 16'hC0DE));
        cyc(p_rd(6, 0, 1), p_rd(7, 1, 0));
        cyc(p_idle(), p_idle());

        cur_req = "R1";
        begin
            pin_t d = p_wr(5, 16'hFFFF);
            d.cs_n = 1'b1;
            cyc(d, p_idle());
            d = p_wr(5, 16'hEEEE, 0, 0);
            cyc(d, p_idle());
            d = p_wr(5, 16'hDDDD);
            d.sem_n = 1'b0;
            cyc(d, p_idle());
        end
        cyc(p_rd(5), p_idle());

        cur_req = "R3";
        cyc(p_wr(8, 16'h0808), p_rd(5));
        cyc(p_wr(8, 16'h1818), p_rd(8));
        cyc(p_idle(), p_rd(8));
        cyc(p_idle(), p_idle());

        cur_req = "R4";
        begin
            pin_t d;
            cyc(p_rd(5), p_idle());
            d = p_idle(); d.oe_n = 1'b1;
            cyc(d, p_idle());
            d = p_rd(8); d.oe_n = 1'b1;
            cyc(d, p_idle());
            cyc(p_idle(), p_idle());
        end

        cur_req = "R5";
        cyc(p_wr(20, 16'h1111), p_wr(20, 16'h2222));
        cyc(p_rd(20), p_rd(20));
        cyc(p_wr(21, 16'h3333), p_idle());
        cyc(p_wr(21, 16'h4444), p_rd(21));
        cyc(p_rd(21), p_idle());
        cyc(p_idle(), p_idle());

        cur_req = "R6";
        cyc(p_idle(), p_wr(30, 16'h5555));
        cyc(p_rd(30), p_idle());
        cyc(p_rd(30), p_wr(30, 16'h6666));
        cyc(p_rd(30), p_wr(30, 16'h6666));
        cyc(p_idle(), p_wr(30, 16'h7777));
        cyc(p_wr(30, 16'h8888), p_wr(30, 16'h7777));
        cyc(p_wr(30, 16'h8888), p_wr(30, 16'h9999));
        cyc(p_rd(30), p_idle());
        cyc(p_idle(), p_idle());

        cur_req = "R8";
        cyc(p_sw(5, 0), p_idle());
        cyc(p_rd(5), p_idle());
        begin
            pin_t d = p_sw(4, 0);
            d.cs_n = 1'b0;
            cyc(d, p_idle());
            cyc(p_sr(4), p_sr(4));
        end
        cyc(p_sw(5, 1), p_idle());

        cur_req = "R9";
        cyc(p_sw(3, 0), p_sr(3));
        cyc(p_sr(3), p_sr(11));
        cyc(p_idle(), p_sw(3, 0));
        cyc(p_sr(3), p_sr(3));
        cyc(p_idle(), p_sw(3, 1));
        cyc(p_sr(3), p_idle());
        cyc(p_sw(3, 1), p_idle());
        cyc(p_idle(), p_sw(3, 0));
        cyc(p_sr(3), p_sr(3));
        cyc(p_idle(), p_idle());

        cur_req = "R10";
        cyc(p_sw(6, 0), p_sw(10'h10E, 0));
        cyc(p_sr(6), p_sr(6));
        cyc(p_idle(), p_sw(6, 1));
        cyc(p_sr(6), p_sr(6));
        cyc(p_idle(), p_idle());

        cur_req = "R11";
        cyc(p_wr(TOP, 16'hABCD), p_idle());
        cyc(p_idle(), p_idle());
        cyc(p_idle(), p_rd(TOP));
        cyc(p_idle(), p_wr(TOP - 1, 16'h0F0F));
        cyc(p_idle(), p_idle());
        cyc(p_rd(TOP - 1), p_idle());
        cyc(p_wr(TOP, 16'h1357), p_idle());
        cyc(p_wr(TOP, 16'h2468), p_rd(TOP));
        cyc(p_idle(), p_idle());
        cyc(p_wr(TOP, 16'h3579), p_wr(TOP, 16'h0000));
        cyc(p_idle(), p_rd(TOP));
        cyc(p_idle(), p_idle());

        cur_req = "R7";
        master = 1'b0;
        lbi = 1'b1;
        cyc(p_wr(40, 16'h9999), p_idle());
        lbi = 1'b0; rbi = 1'b1;
        cyc(p_wr(40, 16'hAAAA), p_wr(41, 16'hBBBB));
        rbi = 1'b0;
        cyc(p_rd(40), p_wr(41, 16'hCCCC));
        cyc(p_idle(), p_rd(41));
        lbi = 1'b1; rbi = 1'b1;
        cyc(p_idle(), p_idle());
        master = 1'b1;
        cyc(p_wr(42, 16'h4242), p_wr(43, 16'h4343));
        cyc(p_rd(42), p_rd(43));
        lbi = 1'b0; rbi = 1'b0;
        cyc(p_idle(), p_idle());

        cur_req = "R12";
        rst = 1'b1;
        cyc(p_idle(), p_idle());
        rst = 1'b0;
        cyc(p_idle(), p_idle());
        cyc(p_sr(6), p_rd(42));
        cyc(p_idle(), p_idle());

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule